// File: doc/BRIEF.md
# I2C Receive Data Holding Register with Clock Stretching

This block sits on the receive side of an I2C controller, between the bit-level shifter and the software-visible data register. When the shifter finishes a byte, the block decides whether that byte counts as received data. If it does, the block copies the byte into a single holding register and sets a full flag. A receive interrupt follows the flag when interrupts are enabled.

Software reads the holding register to take the byte, and the read clears the flag. A slow reader must not lose data. So when the next byte reaches its last data bit while the flag is still set, the block asks the bus side to hold SCL low. It keeps asking until the read arrives, and the shifter keeps its byte in the meantime.

Byte selection depends on the mode:
- In master mode, every completed byte is taken.
- In slave mode, the address byte and any data that follows a non-matching address are passed over.
- An interactive mode overrides the slave rule, and then every byte is taken.

Top module: `i2c_rx_holdbuf`

## Requirements
- R1: After reset `rx_full`, `scl_hold` and `rx_irq` are 0 and `rd_data` is 0.
- R2: With `slave_mode`=0, a `byte_done` strobe while the register is empty loads `byte_data` into `rd_data` and sets `rx_full` on the next clock, whatever `addr_phase` and `addr_match` are.
- R3: With `slave_mode`=1 and `interactive_en`=0, a byte with `addr_phase`=1 is not taken: `rx_full` and `rd_data` keep their values.
- R4: With `slave_mode`=1 and `interactive_en`=0, a data byte (`addr_phase`=0) is taken only when `addr_match`=1; otherwise it is ignored.
- R5: With `slave_mode`=1 and `interactive_en`=1, every byte is taken, both address and data, matching or not.
- R6: A `dreg_rd` strobe with no byte being taken in the same cycle clears `rx_full` on the next clock.
- R7: `rx_irq` is high exactly when `rx_full`=1 and `rx_ie`=1. It falls in the same cycle as `rx_full`.
- R8: `scl_hold` is high when `rx_full`=1, `last_bit`=1 and the byte currently on the wire would be taken (by the rules of R2 to R5). It drops in the cycle after the `dreg_rd` that clears the flag.
- R9: A byte that would be taken while `rx_full`=1 and no read occurs in that cycle is refused: `rd_data` keeps the older byte and `rx_full` stays 1.
- R10: A taken byte that coincides with `dreg_rd` replaces `rd_data`, and `rx_full` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_mode | input | 1 | 1 selects slave operation |
| interactive_en | input | 1 | Take every received byte in slave mode |
| rx_ie | input | 1 | Receive interrupt enable |
| byte_done | input | 1 | One-cycle strobe: shifter finished a byte |
| byte_data | input | DW | Byte from the shifter |
| addr_phase | input | 1 | Current byte is an address byte |
| addr_match | input | 1 | Addressed transaction matched this slave |
| last_bit | input | 1 | Shifter is in the last data bit of a byte |
| dreg_rd | input | 1 | Software read strobe of the data register |
| rd_data | output | DW | Holding register contents |
| rx_full | output | 1 | Receive data full flag |
| rx_irq | output | 1 | Receive interrupt |
| scl_hold | output | 1 | Request to hold SCL low |

## Verification
The bench sweeps all sixteen combinations of mode, interactive setting, address phase and match result. For each one it checks whether the byte is taken. A design that mis-gates would either raise the flag on an address byte or drop valid data.

The bench then parks a byte and presents the last bit of the next one. It checks that the hold appears and that it lifts exactly one cycle after the read. A stretcher that releases early or late shows up there.

The collision cases come last: a strobe against a full register with no read, and a strobe in the same cycle as a read. A design that overwrites the older byte fails the first case. A design that loses the newer byte fails the second.

// File: rtl/i2c_rx_holdbuf.sv
module i2c_rx_holdbuf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slave_mode,
  input  logic          interactive_en,
  input  logic          rx_ie,
  input  logic          byte_done,
  input  logic [DW-1:0] byte_data,
  input  logic          addr_phase,
  input  logic          addr_match,
  input  logic          last_bit,
  input  logic          dreg_rd,
  output logic [DW-1:0] rd_data,
  output logic          rx_full,
  output logic          rx_irq,
  output logic          scl_hold
);

  logic qualify;
  logic take;

  assign qualify = !slave_mode || interactive_en || (!addr_phase && addr_match);
  assign take    = byte_done && qualify && (!rx_full || dreg_rd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_full <= 1'b0;
      rd_data <= '0;
    end else if (take) begin
      rx_full <= 1'b1;
      rd_data <= byte_data;
    end else if (dreg_rd) begin
      rx_full <= 1'b0;
    end
  end

  assign rx_irq   = rx_full && rx_ie;
  assign scl_hold = rx_full && last_bit && qualify;

endmodule

module i2c_rx_holdbuf_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          slave_mode,
  input logic          interactive_en,
  input logic          rx_ie,
  input logic          byte_done,
  input logic [DW-1:0] byte_data,
  input logic          addr_phase,
  input logic          dreg_rd,
  input logic [DW-1:0] rd_data,
  input logic          rx_full,
  input logic          rx_irq,
  input logic          scl_hold
);

  AST_MASTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && byte_done && !rx_full) |=> (rx_full && rd_data == $past(byte_data))); // R2

  AST_ADDR_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_mode && !interactive_en && addr_phase && byte_done && !rx_full && !dreg_rd) |=> !rx_full); // R3

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (dreg_rd && !byte_done) |=> !rx_full); // R6

  AST_IRQ_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> (rx_full && rx_ie)); // R7

  AST_HOLD_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hold |-> rx_full); // R8

  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !dreg_rd) |=> (rx_full && $stable(rd_data))); // R9

endmodule

bind i2c_rx_holdbuf i2c_rx_holdbuf_chk #(.DW(DW)) i_chk (
  .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode), .interactive_en(interactive_en),
  .rx_ie(rx_ie), .byte_done(byte_done), .byte_data(byte_data), .addr_phase(addr_phase),
  .dreg_rd(dreg_rd), .rd_data(rd_data), .rx_full(rx_full), .rx_irq(rx_irq),
  .scl_hold(scl_hold)
);

// File: tb/test_i2c_rx_holdbuf.sv
`timescale 1ns/1ps
module test_i2c_rx_holdbuf;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slave_mode = 1'b0, interactive_en = 1'b0, rx_ie = 1'b1;
  logic byte_done = 1'b0, addr_phase = 1'b0, addr_match = 1'b0, last_bit = 1'b0, dreg_rd = 1'b0;
  logic [DW-1:0] byte_data = '0;
  logic [DW-1:0] rd_data;
  logic rx_full, rx_irq, scl_hold;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  i2c_rx_holdbuf #(.DW(DW)) i_i2c_rx_holdbuf (
    .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode), .interactive_en(interactive_en),
    .rx_ie(rx_ie), .byte_done(byte_done), .byte_data(byte_data), .addr_phase(addr_phase),
    .addr_match(addr_match), .last_bit(last_bit), .dreg_rd(dreg_rd), .rd_data(rd_data),
    .rx_full(rx_full), .rx_irq(rx_irq), .scl_hold(scl_hold)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drain();
    dreg_rd = 1'b1;
    tick();
    dreg_rd = 1'b0;
  endtask

  task automatic send(input logic [DW-1:0] d);
    byte_data = d;
    byte_done = 1'b1;
    tick();
    byte_done = 1'b0;
  endtask

  initial begin
    #1;
    chk("R1 full", rx_full, 0);
    chk("R1 hold", scl_hold, 0);
    chk("R1 irq", rx_irq, 0);
    chk("R1 data", rd_data, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    tick();

    // Gating sweep over mode, interactive, address phase and match
    for (int c = 0; c < 16; c++) begin
      logic exp_take;
      logic [DW-1:0] prev;
      string tag;
      slave_mode     = c[3];
      interactive_en = c[2];
      addr_phase     = c[1];
      addr_match     = c[0];
      exp_take = !c[3] || c[2] || (!c[1] && c[0]);
      if (!c[3]) tag = "R2";
      else if (c[2]) tag = "R5";
      else if (c[1]) tag = "R3";
      else tag = "R4";
      prev = rd_data;
      send(8'h30 + 8'(c * 7));
      chk({tag, " full"}, rx_full, exp_take);
      chk({tag, " data"}, rd_data, exp_take ? 8'h30 + 8'(c * 7) : prev);
      chk("R7 irq", rx_irq, exp_take);
      drain();
      chk("R6 cleared", rx_full, 0);
      chk("R7 irq low", rx_irq, 0);
    end

    // Interrupt enable off
    slave_mode = 1'b0;
    rx_ie = 1'b0;
    send(8'hA5);
    chk("R7 irq masked", rx_irq, 0);
    rx_ie = 1'b1;
    #1;
    chk("R7 irq follows enable", rx_irq, 1);

    // Stretching: full register, next byte at its last bit
    last_bit = 1'b1;
    #1;
    chk("R8 hold asserted", scl_hold, 1);
    tick();
    chk("R8 hold persists", scl_hold, 1);
    dreg_rd = 1'b1;
    #1;
    chk("R8 hold during read cycle", scl_hold, 1);
    tick();
    dreg_rd = 1'b0;
    #1;
    chk("R8 hold released", scl_hold, 0);
    last_bit = 1'b0;

    // No hold when the next byte would not be taken
    send(8'h11);
    slave_mode = 1'b1; interactive_en = 1'b0; addr_phase = 1'b1; last_bit = 1'b1;
    #1;
    chk("R8 no hold for skipped byte", scl_hold, 0);
    last_bit = 1'b0; slave_mode = 1'b0; addr_phase = 1'b0;

    // Refused byte while full
    send(8'h22);
    chk("R9 data kept", rd_data, 8'h11);
    chk("R9 still full", rx_full, 1);

    // Byte coinciding with read
    dreg_rd = 1'b1;
    send(8'h33);
    dreg_rd = 1'b0;
    chk("R10 data replaced", rd_data, 8'h33);
    chk("R10 still full", rx_full, 1);
    drain();
    chk("R6 final clear", rx_full, 0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule